// File: doc/BRIEF.md
# Power-On Run Control with Auto-Start

This block sequences a processor's timing generator through power-up, start, stop and power-fail. It watches a power-good input. It holds a CLEAR output while power is bad, and it runs a power-settling period before it lets timing start. Stop requests and power loss are lined up with the generator's third and fourth time pulses, so that a cycle already under way always runs to its end.

RUN and GO are set together by a start request, or by the auto-start function once per power-up. A stop request, or loss of power, clears RUN at the next third time pulse. GO then clears at the following fourth time pulse. On power loss, CLEAR is delayed long enough for this to happen cleanly.

The block also forms the auto-start program address from five one-hot switch selects. It forms the start field from a field-7 select, which only takes effect when memory extension is present. All delays are parameters counted in clock cycles.

Top module: `pwr_run_ctl`

## Requirements
- R1: `clear_o` is 1 in reset. It changes to follow the inverse of `pwr_good` only after `pwr_good` has held its new level for CLR_DLY consecutive clock edges. This applies to both the rising and the falling edge of power.
- R2: `settling_o` is 1 in reset and goes to 1 on the first edge where `pwr_good` is low. It returns to 0 after SETTLE consecutive edges with `pwr_good` high.
- R3: A start sets `run_o` and `go_o` on the next edge, but only when all of the following hold: `pwr_good` is high, `settling_o` and `clear_o` are low, `run_o` and `go_o` are both low, and `stop_req` is low. A `start_req` under any other condition has no effect.
- R4: With `autostart_en` high, one start is issued by itself, on the edge after `settling_o` falls. No further automatic start happens until the next power-up.
- R5: When `stop_req` is seen, or `pwr_good` is low, while `run_o` is 1, `run_o` stays 1 until the first edge with `tp3` high, and clears at that edge.
- R6: `go_o` clears on the first edge with `tp4` high while `run_o` is already 0. A `tp4` while `run_o` is still 1 leaves `go_o` set, so `go_o` is 1 whenever `run_o` is 1.
- R7: While `clear_o` is 1, `run_o` and `go_o` are forced to 0 on the next edge.
- R8: `start_addr` is built from `addr_sel`. Bit 4 gives octal 4000, bit 3 gives 2000, bit 2 gives 1000, bit 1 gives 0400 and bit 0 gives 0200. When no bit is set, the address is 0000.
- R9: When more than one `addr_sel` bit is set, `sel_err` is 1 and `start_addr` is 0000.
- R10: `start_field` is 7 when both `fld7_sel` and `mem_ext_present` are 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply voltages are in range |
| start_req | input | 1 | Manual start request |
| stop_req | input | 1 | Stop request |
| autostart_en | input | 1 | Start by itself after power-up |
| addr_sel | input | 5 | One-hot auto-start address selects (4000, 2000, 1000, 0400, 0200 octal) |
| fld7_sel | input | 1 | Select field 7 |
| mem_ext_present | input | 1 | Memory extension is installed |
| tp3 | input | 1 | Third time pulse from the timing generator |
| tp4 | input | 1 | Fourth time pulse from the timing generator |
| clear_o | output | 1 | System clear |
| run_o | output | 1 | RUN flag; timing cycles are being generated |
| go_o | output | 1 | GO flag; enables the timing register |
| settling_o | output | 1 | Power-settling period is active |
| start_addr | output | 12 | Auto-start program address |
| start_field | output | 3 | Auto-start instruction and data field |
| sel_err | output | 1 | More than one address select is active |

## Verification
The address and field logic is tried with these switch patterns:
- each single select on its own, which tells the five weights apart;
- no select at all, which checks the zero default;
- pairs of selects and all five together, which separate a true error from a single select;
- field-7 with and without memory extension present.

The sequencing is tried with several orders of pulses:
- a manual power-up, then a start;
- a stop where `tp4` arrives before `tp3`, which shows that GO waits for the `tp4` that follows the `tp3`;
- a start inside the window where RUN is low but GO is still high;
- a power loss with the time pulses arriving, and one without them, which separates the aligned shutdown from the forced CLEAR;
- two auto-start power-ups, which show that the automatic start is re-armed on each power-up and fires only once.

// File: rtl/pwr_run_ctl.sv
module pwr_run_ctl #(
  parameter int unsigned CLR_DLY = 600,
  parameter int unsigned SETTLE  = 2000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_good,
  input  logic        start_req,
  input  logic        stop_req,
  input  logic        autostart_en,
  input  logic [4:0]  addr_sel,
  input  logic        fld7_sel,
  input  logic        mem_ext_present,
  input  logic        tp3,
  input  logic        tp4,
  output logic        clear_o,
  output logic        run_o,
  output logic        go_o,
  output logic        settling_o,
  output logic [11:0] start_addr,
  output logic [2:0]  start_field,
  output logic        sel_err
);
  localparam int CLR_W = $clog2(CLR_DLY + 1);
  localparam int SET_W = $clog2(SETTLE + 1);

  logic [CLR_W-1:0] clr_cnt;
  logic [SET_W-1:0] set_cnt;
  logic halt_pend, auto_pend, can_start, fire;

  // CLEAR follows power-good only after it has been stable for CLR_DLY edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clear_o <= 1'b1;
      clr_cnt <= '0;
    end else if (pwr_good == clear_o) begin
      if (clr_cnt == CLR_W'(CLR_DLY - 1)) begin
        clear_o <= ~clear_o;
        clr_cnt <= '0;
      end else begin
        clr_cnt <= clr_cnt + 1'b1;
      end
    end else begin
      clr_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settling_o <= 1'b1;
      set_cnt    <= '0;
    end else if (!pwr_good) begin
      settling_o <= 1'b1;
      set_cnt    <= '0;
    end else if (settling_o) begin
      if (set_cnt == SET_W'(SETTLE - 1)) begin
        settling_o <= 1'b0;
        set_cnt    <= '0;
      end else begin
        set_cnt <= set_cnt + 1'b1;
      end
    end
  end

  assign can_start = pwr_good && !settling_o && !clear_o && !run_o && !go_o && !stop_req;
  assign fire      = can_start && (start_req || (autostart_en && auto_pend));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) auto_pend <= 1'b1;
    else if (settling_o) auto_pend <= 1'b1;
    else if (fire) auto_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o     <= 1'b0;
      go_o      <= 1'b0;
      halt_pend <= 1'b0;
    end else if (clear_o) begin
      run_o     <= 1'b0;
      go_o      <= 1'b0;
      halt_pend <= 1'b0;
    end else if (fire) begin
      run_o <= 1'b1;
      go_o  <= 1'b1;
    end else begin
      if (run_o && tp3 && (halt_pend || stop_req || !pwr_good)) begin
        run_o     <= 1'b0;
        halt_pend <= 1'b0;
      end else if (run_o && (stop_req || !pwr_good)) begin
        halt_pend <= 1'b1;
      end
      if (!run_o && go_o && tp4) go_o <= 1'b0;
    end
  end

  assign sel_err     = $countones(addr_sel) > 1;
  assign start_addr  = sel_err ? 12'o0000 : {addr_sel, 7'b0};
  assign start_field = {3{fld7_sel & mem_ext_present}};

  assert_clear_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clear_o) |-> $past(!pwr_good));
  assert_run_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> $past(pwr_good && !settling_o && !clear_o && !go_o));
  assert_run_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_o) |-> $past(tp3 || clear_o));
  assert_go_covers_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> go_o);
  assert_go_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go_o) |-> $past((tp4 && !run_o) || clear_o));
  assert_clear_forces_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |=> (!run_o && !go_o));
  assert_err_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> start_addr == 12'o0000);
  assert_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ext_present |-> start_field == 3'd0);
endmodule

// File: tb/pwr_run_ctl_tb.sv
module pwr_run_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;
  localparam int S = 40;

  logic clk = 0, rst_n = 0;
  logic pwr_good = 0, start_req = 0, stop_req = 0, autostart_en = 0;
  logic [4:0] addr_sel = '0;
  logic fld7_sel = 0, mem_ext_present = 0, tp3 = 0, tp4 = 0;
  logic clear_o, run_o, go_o, settling_o, sel_err;
  logic [11:0] start_addr;
  logic [2:0] start_field;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_run_ctl #(.CLR_DLY(D), .SETTLE(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .start_req(start_req),
    .stop_req(stop_req), .autostart_en(autostart_en), .addr_sel(addr_sel),
    .fld7_sel(fld7_sel), .mem_ext_present(mem_ext_present), .tp3(tp3), .tp4(tp4),
    .clear_o(clear_o), .run_o(run_o), .go_o(go_o), .settling_o(settling_o),
    .start_addr(start_addr), .start_field(start_field), .sel_err(sel_err));

  // sel, fld7, mem_ext, exp addr, exp field, exp err
  localparam logic [22:0] VEC [10] = '{
    {5'b00000, 1'b0, 1'b1, 12'o0000, 3'd0, 1'b0},
    {5'b10000, 1'b0, 1'b1, 12'o4000, 3'd0, 1'b0},
    {5'b01000, 1'b1, 1'b1, 12'o2000, 3'd7, 1'b0},
    {5'b00100, 1'b0, 1'b0, 12'o1000, 3'd0, 1'b0},
    {5'b00010, 1'b1, 1'b1, 12'o0400, 3'd7, 1'b0},
    {5'b00001, 1'b1, 1'b0, 12'o0200, 3'd0, 1'b0},
    {5'b10010, 1'b0, 1'b1, 12'o0000, 3'd0, 1'b1},
    {5'b00011, 1'b1, 1'b1, 12'o0000, 3'd7, 1'b1},
    {5'b11111, 1'b0, 1'b0, 12'o0000, 3'd0, 1'b1},
    {5'b00000, 1'b1, 1'b1, 12'o0000, 3'd7, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_req = 1; tick(1); start_req = 0;
  endtask

  task automatic pulse_tp3();
    tp3 = 1; tick(1); tp3 = 0;
  endtask

  task automatic pulse_tp4();
    tp4 = 1; tick(1); tp4 = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 reset clear", clear_o, 1);
    chk("R2 reset settling", settling_o, 1);
    chk("R3 reset run", run_o, 0);
    chk("R6 reset go", go_o, 0);
    rst_n = 1;
    tick(2);

    for (int i = 0; i < 10; i++) begin
      {addr_sel, fld7_sel, mem_ext_present} = VEC[i][22:16];
      #1;
      chk("R8/R9 addr", start_addr, VEC[i][15:4]);
      chk("R10 field", start_field, VEC[i][3:1]);
      chk("R9 err", sel_err, VEC[i][0]);
      tick(1);
    end

    // manual power-up
    pwr_good = 1;
    tick(D - 1);
    chk("R1 clear held during delay", clear_o, 1);
    tick(1);
    chk("R1 clear negated", clear_o, 0);
    pulse_start();
    chk("R3 start ignored while settling", run_o, 0);
    tick(S - 1 - (D + 1));
    chk("R2 settling held", settling_o, 1);
    tick(1);
    chk("R2 settling ended", settling_o, 0);
    chk("R4 no auto start when disabled", run_o, 0);
    pulse_start();
    chk("R3 run set", run_o, 1);
    chk("R3 go set", go_o, 1);

    // stop sequence with early tp4
    stop_req = 1; tick(1); stop_req = 0;
    chk("R5 run waits for tp3", run_o, 1);
    pulse_tp4();
    chk("R6 early tp4 keeps go", go_o, 1);
    chk("R5 early tp4 keeps run", run_o, 1);
    pulse_tp3();
    chk("R5 run cleared at tp3", run_o, 0);
    chk("R6 go held after tp3", go_o, 1);
    pulse_start();
    chk("R3 start ignored while go high", run_o, 0);
    pulse_tp4();
    chk("R6 go cleared at tp4", go_o, 0);
    pulse_start();
    chk("R3 restart", run_o, 1);

    // power loss with time pulses
    pwr_good = 0;
    pulse_tp3();
    chk("R5 run cleared at tp3 on power loss", run_o, 0);
    chk("R2 settling on power loss", settling_o, 1);
    chk("R1 clear still delayed", clear_o, 0);
    pulse_tp4();
    chk("R6 go cleared on power loss", go_o, 0);
    tick(D - 3);
    chk("R1 clear delay on fall", clear_o, 0);
    tick(1);
    chk("R1 clear asserted", clear_o, 1);

    // auto-start power-up, then power loss without pulses
    autostart_en = 1;
    pwr_good = 1;
    tick(S);
    chk("R4 auto start not before settling ends", run_o, 0);
    tick(1);
    chk("R4 auto start run", run_o, 1);
    chk("R4 auto start go", go_o, 1);
    pwr_good = 0;
    tick(D);
    chk("R1 clear after power loss", clear_o, 1);
    chk("R7 run before forced clear", run_o, 1);
    tick(1);
    chk("R7 run forced low", run_o, 0);
    chk("R7 go forced low", go_o, 0);

    // second auto-start power-up, one-shot behaviour
    pwr_good = 1;
    tick(S + 1);
    chk("R4 auto start rearmed", run_o, 1);
    stop_req = 1; tick(1); stop_req = 0;
    pulse_tp3();
    pulse_tp4();
    chk("R6 go cleared after stop", go_o, 0);
    tick(5);
    chk("R4 auto start only once", run_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule